// File: doc/BRIEF.md
# Dual Timer Peripheral with Countdown Event Timer and Free-Running Counter

The block has two timers behind a 32-bit register bus. The event timer counts down 56 bits and can run once or reload itself. The second timer is a 64-bit counter that never stops. Both timers move forward by one step on each clock cycle where the shared `tick` input is high.

The event timer's reload value is split across two registers. The low word has its own register at 0x000. The upper bits share the control word at 0x004 with the run and reload bits. Software writes the low word first. The later control write, with its load bit set, moves the full value into the counter.

Each expiry sets a pending flag. A single level interrupt shows that flag whenever the interrupt is unmasked. The mask is changed only through a set strobe and a clear strobe, and the pending flag is cleared by writing 1. Software reads the 64-bit counter low half first. That read copies the high half into a holding register, so the following high read belongs to the same instant.

Top module: `dual_tick_timer`

## Requirements
- R1: After reset, `irq` is 0, a read of the control word at 0x004 returns 0, and a read of the low half at 0x024 returns bits 31:0 of the parameter `FREE_RST`.
- R2: A control write at 0x004 stores the upper reload bits from data bits 23:0, the run bit from bit 24 and the reload-mode bit from bit 28. A read of 0x004 returns these three fields in the same positions, with bit 30 and every other bit at 0. A read of 0x000 returns the stored low reload word.
- R3: A control write with data bit 30 set copies {data bits 23:0, low word at 0x000} into the countdown counter. A control write with bit 30 clear leaves the counter as it was.
- R4: In one-shot mode (bit 28 = 0), after loading N ≥ 2 and setting the run bit, the pending flag sets on the N-th tick. The run bit then clears, so 0x004 bit 24 reads 0 and the timer does not expire again.
- R5: In reload mode (bit 28 = 1), the pending flag sets every N ticks. The counter reloads the stored value and the run bit stays at 1.
- R6: Writing 0 to the control word stops the event timer, and no expiry follows on any later tick.
- R7: Writing 1 in bit 0 at 0x02C unmasks the interrupt, and writing 1 in bit 0 at 0x030 masks it. Writes with bit 0 at 0 to either address change nothing.
- R8: `irq` is high exactly while the pending flag is set and the interrupt is unmasked. A masked event stays pending and raises `irq` once it is unmasked.
- R9: Writing 1 in bit 0 at 0x034 clears the pending flag, unless an expiry occurs in the same cycle.
- R10: The 64-bit counter adds 1 on every tick and wraps around at the top of its range.
- R11: A read at 0x024 returns the current low half and copies the current high half into a holding register. Reads at 0x028 return that held value, so a low-then-high pair is coherent even if a carry occurs between the two reads.
- R12: In cycles where `tick` is low, neither the 64-bit counter nor the countdown counter changes.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| tick | input | 1 | Count enable shared by both timers |
| bus_addr | input | 8 | Byte address of the register |
| bus_wr | input | 1 | Write strobe |
| bus_wdata | input | 32 | Write data |
| bus_rd | input | 1 | Read strobe |
| bus_rdata | output | 32 | Read data, valid in the same cycle as `bus_rd` |
| irq | output | 1 | Level interrupt: pending flag while unmasked |

## Verification
The event timer is driven from a table that mixes short and longer reload values in both one-shot and reload modes. This separates an off-by-one in the expiry tick from a missing reload, and a run bit that fails to clear from one that clears by mistake. The mask, unmask and clear writes are sent with bit 0 at 0 and at 1. This shows whether zero bits are wrongly acted on and whether masking hides the pending flag or destroys it. The 64-bit counter starts just below a carry out of its low half. A low read is then placed before the carry and the matching high read after it, which tells a held high half apart from a live one.

// File: rtl/dual_tick_timer.sv
module dual_tick_timer #(
  parameter int ADDR_W = 8,
  parameter int EVT_W = 56,
  parameter logic [63:0] FREE_RST = 64'd0
) (
  input  logic              clk,
  input  logic              rst_n,
  input  logic              tick,
  input  logic [ADDR_W-1:0] bus_addr,
  input  logic              bus_wr,
  input  logic [31:0]       bus_wdata,
  input  logic              bus_rd,
  output logic [31:0]       bus_rdata,
  output logic              irq
);
  localparam int HI_W = EVT_W - 32;
  localparam int FREE_W = 64;
  localparam logic [ADDR_W-1:0] A_LO    = ADDR_W'(8'h00);
  localparam logic [ADDR_W-1:0] A_CTRL  = ADDR_W'(8'h04);
  localparam logic [ADDR_W-1:0] A_FLO   = ADDR_W'(8'h24);
  localparam logic [ADDR_W-1:0] A_FHI   = ADDR_W'(8'h28);
  localparam logic [ADDR_W-1:0] A_MSET  = ADDR_W'(8'h2C);
  localparam logic [ADDR_W-1:0] A_MCLR  = ADDR_W'(8'h30);
  localparam logic [ADDR_W-1:0] A_PCLR  = ADDR_W'(8'h34);
  localparam int B_RUN = 24;
  localparam int B_REP = 28;
  localparam int B_LD  = 30;

  logic [31:0]       load_lo;
  logic [HI_W-1:0]   load_hi;
  logic              run, rep, pend, unmask;
  logic [EVT_W-1:0]  evt_cnt;
  logic [FREE_W-1:0] free_cnt;
  logic [31:0]       hi_hold;

  wire wr_lo   = bus_wr && bus_addr == A_LO;
  wire wr_ctrl = bus_wr && bus_addr == A_CTRL;
  wire wr_mset = bus_wr && bus_addr == A_MSET && bus_wdata[0];
  wire wr_mclr = bus_wr && bus_addr == A_MCLR && bus_wdata[0];
  wire wr_pclr = bus_wr && bus_addr == A_PCLR && bus_wdata[0];
  wire rd_flo  = bus_rd && bus_addr == A_FLO;
  wire step    = tick && run && !wr_ctrl;
  wire expire  = step && evt_cnt <= EVT_W'(1);

  assign irq = pend & unmask;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      load_lo <= '0;
      load_hi <= '0;
      run     <= 1'b0;
      rep     <= 1'b0;
      evt_cnt <= '0;
    end else if (wr_ctrl) begin
      load_hi <= bus_wdata[HI_W-1:0];
      run     <= bus_wdata[B_RUN];
      rep     <= bus_wdata[B_REP];
      if (bus_wdata[B_LD]) evt_cnt <= {bus_wdata[HI_W-1:0], load_lo};
    end else begin
      if (wr_lo) load_lo <= bus_wdata;
      if (expire) begin
        if (rep) evt_cnt <= {load_hi, load_lo};
        else begin
          run     <= 1'b0;
          evt_cnt <= '0;
        end
      end else if (step) evt_cnt <= evt_cnt - EVT_W'(1);
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      pend   <= 1'b0;
      unmask <= 1'b0;
    end else begin
      if (expire) pend <= 1'b1;
      else if (wr_pclr) pend <= 1'b0;
      if (wr_mset) unmask <= 1'b1;
      else if (wr_mclr) unmask <= 1'b0;
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      free_cnt <= FREE_RST;
      hi_hold  <= '0;
    end else begin
      if (tick) free_cnt <= free_cnt + FREE_W'(1);
      if (rd_flo) hi_hold <= free_cnt[63:32];
    end
  end

  always_comb begin
    bus_rdata = '0;
    if (bus_rd) begin
      case (bus_addr)
        A_LO:    bus_rdata = load_lo;
        A_CTRL:  bus_rdata = {3'b000, rep, 3'b000, run, 24'(load_hi)};
        A_FLO:   bus_rdata = free_cnt[31:0];
        A_FHI:   bus_rdata = hi_hold;
        default: bus_rdata = '0;
      endcase
    end
  end

  p_free_step_r10: assert property (@(posedge clk) disable iff (!rst_n)
    tick |=> free_cnt == $past(free_cnt) + FREE_W'(1));
  p_idle_hold_r12: assert property (@(posedge clk) disable iff (!rst_n)
    (!tick && !wr_ctrl) |=> ($stable(free_cnt) && $stable(evt_cnt)));
  p_hold_latch_r11: assert property (@(posedge clk) disable iff (!rst_n)
    rd_flo |=> hi_hold == $past(free_cnt[63:32]));
  p_oneshot_stop_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && !rep) |=> (!run && pend));
  p_reload_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (expire && rep) |=> (run && evt_cnt == {$past(load_hi), $past(load_lo)}));
  p_ctrl_stop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_ctrl && bus_wdata == 32'd0) |=> !run);
  p_mask_set_r7: assert property (@(posedge clk) disable iff (!rst_n)
    wr_mset |=> unmask);
  p_pend_clear_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (wr_pclr && !expire) |=> !pend);
  p_pend_source_r8: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(pend) |-> $past(tick && run));
endmodule

// File: tb/sim_dual_tick_timer.sv
module sim_dual_tick_timer;
  logic clk = 1'b0, rst_n = 1'b0, tick = 1'b0;
  logic [7:0] bus_addr = '0;
  logic bus_wr = 1'b0, bus_rd = 1'b0;
  logic [31:0] bus_wdata = '0;
  logic [31:0] bus_rdata;
  logic irq;
  int checks = 0, fails = 0;

  localparam logic [63:0] START = 64'h0000_0001_FFFF_FFFD;

  dual_tick_timer #(.ADDR_W(8), .EVT_W(56), .FREE_RST(START)) u0 (
    .clk(clk), .rst_n(rst_n), .tick(tick), .bus_addr(bus_addr), .bus_wr(bus_wr),
    .bus_wdata(bus_wdata), .bus_rd(bus_rd), .bus_rdata(bus_rdata), .irq(irq));

  always #10 clk = ~clk;

  // {reload mode, N}
  localparam int NV = 6;
  localparam logic [8:0] VEC [NV] = '{
    {1'b0, 8'd2}, {1'b0, 8'd3}, {1'b1, 8'd5}, {1'b1, 8'd2}, {1'b0, 8'd7}, {1'b1, 8'd4}};

  task automatic chk(input bit ok, input string req, input logic [63:0] act, input logic [63:0] exp);
    checks++;
    if (!ok) begin
      fails++;
      $display("FAIL %s: got %0h expected %0h", req, act, exp);
    end
  endtask

  task automatic wr(input logic [7:0] a, input logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_wdata = d; bus_wr = 1'b1;
    @(negedge clk); bus_wr = 1'b0;
  endtask

  task automatic rd(input logic [7:0] a, output logic [31:0] d);
    @(negedge clk); bus_addr = a; bus_rd = 1'b1;
    #2 d = bus_rdata;
    @(negedge clk); bus_rd = 1'b0;
  endtask

  task automatic tk(input int n);
    for (int i = 0; i < n; i++) begin
      @(negedge clk); tick = 1'b1;
      @(negedge clk); tick = 1'b0;
    end
  endtask

  task automatic count_fire(output int t);
    t = 0;
    do begin tk(1); t++; end while (!irq && t < 40);
  endtask

  initial begin
    repeat (200000) @(posedge clk);
    fails++;
    $display("FAIL watchdog: run did not finish");
    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end

  initial begin
    logic [31:0] d, lo;
    int t;
    repeat (3) @(negedge clk);
    rst_n = 1'b1;
    @(negedge clk);
    chk(irq == 1'b0, "R1 irq", irq, 0);
    rd(8'h04, d); chk(d == 0, "R1 ctrl", d, 0);
    rd(8'h24, d); chk(d == START[31:0], "R1 free low", d, START[31:0]);

    // R12: no tick, no change
    rd(8'h24, d); chk(d == START[31:0], "R12 free hold", d, START[31:0]);
    // R10/R11: coherent pair across a carry
    tk(2);
    rd(8'h24, lo); chk(lo == 32'hFFFF_FFFF, "R10 free step", lo, 32'hFFFF_FFFF);
    tk(1);
    rd(8'h28, d); chk(d == 32'h1, "R11 held high", d, 1);
    rd(8'h24, lo); chk(lo == 0, "R10 wrap low", lo, 0);
    rd(8'h28, d); chk(d == 32'h2, "R11 new high", d, 2);

    // R2/R3: readback fields, load bit reads 0
    wr(8'h30, 1);
    wr(8'h00, 32'h1234_5678);
    rd(8'h00, d); chk(d == 32'h1234_5678, "R2 low word", d, 32'h1234_5678);
    wr(8'h04, 32'h5100_00AB);
    rd(8'h04, d); chk(d == 32'h1100_00AB, "R2 ctrl readback", d, 32'h1100_00AB);
    wr(8'h04, 0);
    rd(8'h04, d); chk(d == 0, "R6 ctrl cleared", d, 0);
    wr(8'h2C, 1);

    // table walk: R3 R4 R5
    for (int v = 0; v < NV; v++) begin
      wr(8'h34, 1);
      wr(8'h00, 32'(VEC[v][7:0]));
      wr(8'h04, 32'h4100_0000 | (32'(VEC[v][8]) << 28));
      count_fire(t);
      chk(t == int'(VEC[v][7:0]), VEC[v][8] ? "R5 first period" : "R4 one-shot delay (R3 load)", t, VEC[v][7:0]);
      rd(8'h04, d);
      chk(d[24] == VEC[v][8], VEC[v][8] ? "R5 run kept" : "R4 run cleared", d[24], VEC[v][8]);
      wr(8'h34, 1);
      if (VEC[v][8]) begin
        count_fire(t);
        chk(t == int'(VEC[v][7:0]), "R5 second period", t, VEC[v][7:0]);
        wr(8'h04, 0);
        wr(8'h34, 1);
      end else begin
        tk(2 * int'(VEC[v][7:0]));
        chk(irq == 1'b0, "R4 no refire", irq, 0);
      end
    end

    // R6: stop mid-count
    wr(8'h00, 2); wr(8'h04, 32'h4100_0000);
    tk(1); wr(8'h04, 0); tk(6);
    chk(irq == 1'b0, "R6 stopped", irq, 0);

    // R12: countdown holds without ticks
    wr(8'h00, 2); wr(8'h04, 32'h4100_0000);
    repeat (10) @(negedge clk);
    chk(irq == 1'b0, "R12 countdown hold", irq, 0);
    tk(2);
    chk(irq == 1'b1, "R12 resumes", irq, 1);
    wr(8'h34, 1);

    // R7/R8/R9: mask and clear
    wr(8'h30, 1);
    wr(8'h00, 3); wr(8'h04, 32'h4100_0000);
    tk(3);
    chk(irq == 1'b0, "R8 masked event", irq, 0);
    wr(8'h2C, 0);
    chk(irq == 1'b0, "R7 zero set ignored", irq, 0);
    wr(8'h2C, 1);
    chk(irq == 1'b1, "R8 unmask shows pending", irq, 1);
    wr(8'h30, 0);
    chk(irq == 1'b1, "R7 zero clear ignored", irq, 1);
    wr(8'h30, 1);
    chk(irq == 1'b0, "R7 mask", irq, 0);
    wr(8'h2C, 1);
    wr(8'h34, 0);
    chk(irq == 1'b1, "R9 zero clear ignored", irq, 1);
    wr(8'h34, 1);
    chk(irq == 1'b0, "R9 pending cleared", irq, 0);

    $display("End of test - %0d assertions evaluated, %0d failures", checks, fails);
    $finish;
  end
endmodule